// File: doc/BRIEF.md
# Byte-Strobed Programming Port

This block is the target-side front end of a parallel programming port. The host presents one byte at a time on an 8-bit bus and marks it with a rising edge on a strobe pin. The strobe arrives asynchronously. It is synchronized to the system clock and edge-detected. On each detected edge, a 2-bit role code sampled with the byte decides what the byte is. It can be half of the 16-bit address register, half of the 16-bit data word, the command byte, or nothing. A byte-select pin chooses the high or low half for address and data bytes.

The latched command is decoded into a one-hot operation vector, and any unlisted command byte raises an illegal flag. The address register is presented two ways, each split into a page number and an offset within the page. The flash view is a 15-bit word address with 128-word pages. The EEPROM view is an 11-bit byte address with 8-byte pages.

Bytes are accepted only after an entry sequence, run by a five-state machine:
- IDLE counts strobe edges while the target is held in reset, high voltage is off and the four enable pins read 0000.
- The sixth such edge moves to ARMED.
- In ARMED, the high-voltage indication moves to GUARD. Release of reset, or a nonzero enable, returns to IDLE.
- GUARD lasts GUARD_CYC clocks. A nonzero enable in GUARD moves to FAILED. A clean window moves to ACTIVE.
- ACTIVE and FAILED both return to IDLE only when the reset hold is released.

Top module: `pbus_prog_port`

## Requirements
- R1: In ACTIVE, a strobe edge with role code 00 loads an address byte, 01 loads a data byte, 10 loads the command byte, and 11 changes no register.
- R2: For address and data bytes, byte-select 1 writes bits [15:8] and byte-select 0 writes bits [7:0]; the other half is kept.
- R3: The command byte drives a one-hot `op_vec`, with bit index shown in brackets: 0x80 chip erase [0], 0x40 write fuses [1], 0x20 write lock [2], 0x10 write flash [3], 0x11 write EEPROM [4], 0x08 read signature/calibration [5], 0x04 read fuses and lock [6], 0x02 read flash [7], 0x03 read EEPROM [8].
- R4: A loaded command byte outside the R3 list sets `cmd_illegal` and leaves `op_vec` all zero; before any command is loaded, both are zero.
- R5: `flash_word` is address bits [6:0] and `flash_page` is address bits [14:7].
- R6: `ee_byte` is address bits [2:0] and `ee_page` is address bits [10:3].
- R7: `prog_active` rises only after these steps, in order: six strobe edges with reset held, high voltage off and enables 0000; then high voltage; then GUARD_CYC clocks with enables 0000.
- R8: Any nonzero enable during the guard window, including its last cycle, sets `entry_fail`. The flag stays set until the reset hold is released. After the window, enables are ignored.
- R9: `data_stb` is high for exactly one clock after each data-byte load and never after an address, command or idle-code strobe.
- R10: While `prog_active` is low, strobes change no address, data or command register.
- R11: With fewer than six qualified strobe edges, high voltage does not start the guard window and `prog_active` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| strobe_in | input | 1 | Asynchronous byte strobe, rising edge active |
| role_sel | input | 2 | Byte role code |
| byte_hi | input | 1 | High/low half select |
| din | input | 8 | Byte bus |
| rst_hold | input | 1 | Target held in reset (low or high-voltage) |
| hv_on | input | 1 | High-voltage reset indication |
| en_pins | input | 4 | Entry enable pins |
| prog_active | output | 1 | Programming mode entered |
| entry_fail | output | 1 | Entry attempt failed, latched |
| op_vec | output | 9 | One-hot decoded operation |
| cmd_illegal | output | 1 | Loaded command not recognised |
| flash_page | output | 8 | Flash page number |
| flash_word | output | 7 | Word within flash page |
| ee_page | output | 8 | EEPROM page number |
| ee_byte | output | 3 | Byte within EEPROM page |
| data_word | output | 16 | Assembled data word |
| data_stb | output | 1 | One-cycle pulse per data-byte load |

## Verification
In the guard state, an enable change and the expiry of the window can fall on the same clock. The bench provokes this by raising an enable exactly on the last guard cycle, and it expects a failed entry, because the enable check has priority. A second run raises the enable one cycle later, and there the bench expects programming mode and a clear fail flag. All 256 command bytes are also swept, and each is judged against the one-hot table and the illegal flag.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_GUARD,
        ST_ACTIVE,
        ST_FAILED
    } entry_st_t;

    typedef enum logic [1:0] {
        ROLE_ADDR = 2'b00,
        ROLE_DATA = 2'b01,
        ROLE_CMD  = 2'b10,
        ROLE_NONE = 2'b11
    } role_t;

    localparam int OP_N        = 9;
    localparam int OP_ERASE    = 0;
    localparam int OP_WR_FUSE  = 1;
    localparam int OP_WR_LOCK  = 2;
    localparam int OP_WR_FLASH = 3;
    localparam int OP_WR_EE    = 4;
    localparam int OP_RD_SIG   = 5;
    localparam int OP_RD_FUSE  = 6;
    localparam int OP_RD_FLASH = 7;
    localparam int OP_RD_EE    = 8;
endpackage

// File: rtl/pbp_edge.sv
module pbp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    p_rise_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pbp_entry.sv
module pbp_entry
    import pbp_pkg::*;
#(
    parameter int MIN_PULSES = 6,
    parameter int GUARD_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse,
    input  logic       rst_hold,
    input  logic       hv_on,
    input  logic [3:0] en_pins,
    output logic       active,
    output logic       failed
);
    localparam int PW = $clog2(MIN_PULSES + 1);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [PW-1:0] P_LAST = PW'(MIN_PULSES - 1);
    localparam logic [GW-1:0] G_LAST = GW'(GUARD_CYC - 1);

    entry_st_t st_q, st_d;
    logic [PW-1:0] pcnt_q;
    logic [GW-1:0] gcnt_q;
    logic qualified;
    logic en_quiet;

    assign en_quiet  = (en_pins == 4'b0000);
    assign qualified = rst_hold && !hv_on && en_quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pcnt_q <= '0;
            gcnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && qualified) begin
                if (pulse && pcnt_q != P_LAST) pcnt_q <= pcnt_q + 1'b1;
            end else begin
                pcnt_q <= '0;
            end
            if (st_q == ST_GUARD) gcnt_q <= gcnt_q + 1'b1;
            else                  gcnt_q <= '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (qualified && pulse && pcnt_q == P_LAST) st_d = ST_ARMED;
            ST_ARMED: begin
                if (!rst_hold || !en_quiet) st_d = ST_IDLE;
                else if (hv_on)             st_d = ST_GUARD;
            end
            ST_GUARD: begin
                if (!rst_hold)              st_d = ST_IDLE;
                else if (!en_quiet)         st_d = ST_FAILED;
                else if (gcnt_q == G_LAST)  st_d = ST_ACTIVE;
            end
            ST_ACTIVE: if (!rst_hold) st_d = ST_IDLE;
            ST_FAILED: if (!rst_hold) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active = (st_q == ST_ACTIVE);
        failed = (st_q == ST_FAILED);
    end

    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAILED && rst_hold) |=> st_q == ST_FAILED);
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE && !rst_hold) |=> st_q == ST_IDLE);
    p_idle_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_ARMED));
endmodule

// File: rtl/pbp_opdec.sv
module pbp_opdec
    import pbp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      cmd,
    input  logic            cmd_valid,
    output logic [OP_N-1:0] op_vec,
    output logic            illegal
);
    always_comb begin
        op_vec  = '0;
        illegal = 1'b0;
        if (cmd_valid) begin
            case (cmd)
                8'h80:   op_vec[OP_ERASE]    = 1'b1;
                8'h40:   op_vec[OP_WR_FUSE]  = 1'b1;
                8'h20:   op_vec[OP_WR_LOCK]  = 1'b1;
                8'h10:   op_vec[OP_WR_FLASH] = 1'b1;
                8'h11:   op_vec[OP_WR_EE]    = 1'b1;
                8'h08:   op_vec[OP_RD_SIG]   = 1'b1;
                8'h04:   op_vec[OP_RD_FUSE]  = 1'b1;
                8'h02:   op_vec[OP_RD_FLASH] = 1'b1;
                8'h03:   op_vec[OP_RD_EE]    = 1'b1;
                default: illegal = 1'b1;
            endcase
        end
    end

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_vec));
    p_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (op_vec == '0));
endmodule

// File: rtl/pbus_prog_port.sv
module pbus_prog_port
    import pbp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSES  = 6,
    parameter int GUARD_CYC   = 16,
    parameter int FLASH_AW    = 15,
    parameter int FLASH_WB    = 7,
    parameter int EE_AW       = 11,
    parameter int EE_BB       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe_in,
    input  logic [1:0]             role_sel,
    input  logic                   byte_hi,
    input  logic [7:0]             din,
    input  logic                   rst_hold,
    input  logic                   hv_on,
    input  logic [3:0]             en_pins,
    output logic                   prog_active,
    output logic                   entry_fail,
    output logic [8:0]             op_vec,
    output logic                   cmd_illegal,
    output logic [FLASH_AW-FLASH_WB-1:0] flash_page,
    output logic [FLASH_WB-1:0]    flash_word,
    output logic [EE_AW-EE_BB-1:0] ee_page,
    output logic [EE_BB-1:0]       ee_byte,
    output logic [15:0]            data_word,
    output logic                   data_stb
);
    logic        pulse;
    logic [15:0] addr_q, data_q;
    logic [7:0]  cmd_q;
    logic        cmd_v_q, stb_q;
    logic        ld_addr, ld_data, ld_cmd;
    role_t       role;

    pbp_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_in(strobe_in), .rise(pulse));

    pbp_entry #(.MIN_PULSES(MIN_PULSES), .GUARD_CYC(GUARD_CYC)) u_entry (
        .clk(clk), .rst_n(rst_n), .pulse(pulse), .rst_hold(rst_hold),
        .hv_on(hv_on), .en_pins(en_pins), .active(prog_active),
        .failed(entry_fail));

    assign role = role_t'(role_sel);

    always_comb begin
        ld_addr = 1'b0;
        ld_data = 1'b0;
        ld_cmd  = 1'b0;
        if (pulse && prog_active) begin
            unique case (role)
                ROLE_ADDR: ld_addr = 1'b1;
                ROLE_DATA: ld_data = 1'b1;
                ROLE_CMD:  ld_cmd  = 1'b1;
                ROLE_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            cmd_q   <= '0;
            cmd_v_q <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            stb_q <= ld_data;
            if (ld_addr) begin
                if (byte_hi) addr_q[15:8] <= din;
                else         addr_q[7:0]  <= din;
            end
            if (ld_data) begin
                if (byte_hi) data_q[15:8] <= din;
                else         data_q[7:0]  <= din;
            end
            if (ld_cmd) begin
                cmd_q   <= din;
                cmd_v_q <= 1'b1;
            end
        end
    end

    pbp_opdec u_dec (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .cmd_valid(cmd_v_q),
        .op_vec(op_vec), .illegal(cmd_illegal));

    assign flash_page = addr_q[FLASH_AW-1:FLASH_WB];
    assign flash_word = addr_q[FLASH_WB-1:0];
    assign ee_page    = addr_q[EE_AW-1:EE_BB];
    assign ee_byte    = addr_q[EE_BB-1:0];
    assign data_word  = data_q;
    assign data_stb   = stb_q;

    p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> !data_stb);
    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_active |=> ($stable(addr_q) && $stable(data_q) && $stable(cmd_q)));
endmodule

// File: tb/sim_pbus_prog_port.sv
module sim_pbus_prog_port;
    localparam int G = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_in = 1'b0;
    logic [1:0] role_sel = 2'b11;
    logic byte_hi = 1'b0;
    logic [7:0] din = 8'h00;
    logic rst_hold = 1'b0;
    logic hv_on = 1'b0;
    logic [3:0] en_pins = 4'b0000;
    logic prog_active, entry_fail, cmd_illegal, data_stb;
    logic [8:0] op_vec;
    logic [7:0] flash_page, ee_page;
    logic [6:0] flash_word;
    logic [2:0] ee_byte;
    logic [15:0] data_word;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbus_prog_port #(.GUARD_CYC(G)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .role_sel(role_sel),
        .byte_hi(byte_hi), .din(din), .rst_hold(rst_hold), .hv_on(hv_on),
        .en_pins(en_pins), .prog_active(prog_active), .entry_fail(entry_fail),
        .op_vec(op_vec), .cmd_illegal(cmd_illegal), .flash_page(flash_page),
        .flash_word(flash_word), .ee_page(ee_page), .ee_byte(ee_byte),
        .data_word(data_word), .data_stb(data_stb));

    always @(negedge clk) if (data_stb) stb_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [1:0] r, input logic hi, input logic [7:0] b);
        @(negedge clk);
        role_sel = r; byte_hi = hi; din = b;
        strobe_in = 1'b1;
        repeat (4) @(negedge clk);
        strobe_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_hold();
        @(negedge clk);
        rst_hold = 1'b0; hv_on = 1'b0; en_pins = 4'b0000;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        @(negedge clk);
        rst_hold = 1'b1; hv_on = 1'b0; en_pins = 4'b0000;
        for (int i = 0; i < n; i++) strobe(2'b11, 1'b0, 8'h00);
    endtask

    task automatic enter();
        pulses(6);
        @(negedge clk); hv_on = 1'b1;
        repeat (G + 3) @(negedge clk);
    endtask

    // Raise an enable after k guard evaluations (the window has G of them).
    task automatic enter_with_glitch(input int k);
        pulses(6);
        @(negedge clk); hv_on = 1'b1;
        @(posedge clk);
        repeat (k) @(posedge clk);
        @(negedge clk); en_pins = 4'b0001;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [9:0] exp_dec(input logic [7:0] c);
        // {illegal, op_vec}
        case (c)
            8'h80: return 10'h001;
            8'h40: return 10'h002;
            8'h20: return 10'h004;
            8'h10: return 10'h008;
            8'h11: return 10'h010;
            8'h08: return 10'h020;
            8'h04: return 10'h040;
            8'h02: return 10'h080;
            8'h03: return 10'h100;
            default: return 10'h200;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("reset active", prog_active, 0);
        chk("reset fail", entry_fail, 0);
        chk("reset R4 op_vec", op_vec, 0);
        chk("reset R4 illegal", cmd_illegal, 0);
        chk("reset stb", data_stb, 0);

        // R11: five qualified edges are not enough
        pulses(5);
        @(negedge clk); hv_on = 1'b1;
        repeat (G + 4) @(negedge clk);
        chk("R11 no entry after 5 edges", prog_active, 0);
        chk("R11 no fail", entry_fail, 0);
        // R10: loads while inactive are ignored
        strobe(2'b01, 1'b0, 8'hAB);
        strobe(2'b00, 1'b1, 8'h5C);
        strobe(2'b10, 1'b0, 8'h80);
        chk("R10 data ignored", data_word, 0);
        chk("R10 addr ignored", {flash_page, flash_word}, 0);
        chk("R10 cmd ignored", op_vec, 0);
        chk("R10 no stb", stb_cnt, 0);
        release_hold();

        // R8: glitch early in the window
        enter_with_glitch(2);
        chk("R8 early glitch fails", entry_fail, 1);
        chk("R8 not active", prog_active, 0);
        @(negedge clk); en_pins = 4'b0000;
        repeat (20) @(negedge clk);
        chk("R8 fail latched", entry_fail, 1);
        release_hold();
        chk("R8 fail cleared on release", entry_fail, 0);

        // R8: glitch on the last guard cycle beats window expiry
        enter_with_glitch(G - 1);
        chk("R8 last-cycle glitch fails", entry_fail, 1);
        chk("R8 last-cycle not active", prog_active, 0);
        release_hold();

        // R7/R8: glitch one cycle after the window is ignored
        enter_with_glitch(G);
        chk("R7 active after clean window", prog_active, 1);
        chk("R8 late glitch ignored", entry_fail, 0);
        @(negedge clk); en_pins = 4'b0000;
        release_hold();

        // R7: normal entry
        enter();
        chk("R7 active", prog_active, 1);

        // R1 R2 R5 R6: address sweep
        for (int i = 0; i < 48; i++) begin
            a = 16'(i * 16'h0A37 + 16'h1234);
            strobe(2'b00, 1'b0, a[7:0]);
            strobe(2'b00, 1'b1, a[15:8]);
            chk("R5 flash_page", flash_page, (a % 32768) / 128);
            chk("R5 flash_word", flash_word, a % 128);
            chk("R6 ee_page", ee_page, (a % 2048) / 8);
            chk("R6 ee_byte", ee_byte, a % 8);
        end
        // R2: one half rewritten, the other kept
        strobe(2'b00, 1'b0, 8'hFF);
        chk("R2 low half only", {flash_page, flash_word}, (32'(a) & 32'h7F00) | 32'hFF);

        // R1 R9 R2: data loads
        s0 = stb_cnt;
        for (int i = 0; i < 16; i++) begin
            strobe(2'b01, 1'b0, 8'(i * 17));
            strobe(2'b01, 1'b1, 8'(255 - i * 3));
            chk("R2 data word", data_word, {8'(255 - i * 3), 8'(i * 17)});
        end
        chk("R9 one stb per data load", stb_cnt - s0, 32);

        // R1 R9: idle code changes nothing and pulses no stb
        s0 = stb_cnt;
        strobe(2'b11, 1'b1, 8'h00);
        strobe(2'b11, 1'b0, 8'h00);
        chk("R1 idle keeps data", data_word, {8'(255 - 45), 8'(255)});
        chk("R1 idle keeps addr", {flash_page, flash_word}, (32'(a) & 32'h7F00) | 32'hFF);
        strobe(2'b00, 1'b1, 8'h12);
        strobe(2'b10, 1'b0, 8'h80);
        chk("R9 no stb for addr/cmd/idle", stb_cnt - s0, 0);

        // R3 R4: exhaustive command sweep
        for (int c = 0; c < 256; c++) begin
            strobe(2'b10, 1'b0, 8'(c));
            chk("R3 op_vec", op_vec, exp_dec(8'(c)) & 10'h1FF);
            chk("R4 illegal", cmd_illegal, exp_dec(8'(c)) >> 9);
        end

        release_hold();
        chk("R8 release leaves active", prog_active, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule